// File: doc/BRIEF.md
# Transaction Packet Framer and Deframer

This block sits between a register-access agent and a byte-serial link to a board-management controller. It takes one register transaction at a time: direction, byte count and a 32-bit target address. It builds an eight-byte header from these fields and wraps the header, plus any write payload, in a framed byte packet. The packet goes out on a valid/ready byte stream. Reserved byte values inside the packet body are escaped, so that the far end can always find the packet boundaries.

On the return path the block watches an incoming valid/ready byte stream and drops everything until a start marker arrives. It then removes the framing and escape codes and passes the recovered payload bytes downstream, marking the final byte. The block also counts the response bytes of the open transaction. A write must be answered by four bytes that echo the requested size. A read must return exactly the requested number of bytes. When the final byte arrives, the block pulses a completion strobe and sets an error flag if the response was wrong.

The layer that stuffs idle bytes and the serial shifter sit below this block and are outside it. The responder is expected to send its packet as a start marker followed directly by the body, with no channel prefix.

Top module: `txn_framer`

## Requirements
- R1: The header is eight bytes: the opcode, a zero byte, the 16-bit size most significant byte first, then the 32-bit address most significant byte first. The opcode is 0x00 for a write and 0x10 for a read when the size is 4 or less. It is 0x04 for a write and 0x14 for a read when the size is above 4.
- R2: Every outgoing packet opens with 0x7A, then 0x7C, then the channel number 0x00.
- R3: The end marker 0x7B is sent immediately before the final body byte, and that byte follows it.
- R4: A body byte in the range 0x7A to 0x7D is sent as 0x7D followed by the byte XOR 0x20. Every other body byte is sent unchanged.
- R5: A read packet body is the header alone. A write packet body is the header followed by exactly size payload bytes, taken in order from the write-data stream.
- R6: Incoming bytes before a 0x7A start code are discarded and produce no response byte.
- R7: Inside a packet, 0x7A, 0x7C or 0x7D consumes the next byte and outputs it XOR 0x20. 0x7B makes the next byte the final one: it is unescaped the same way if it is one of those three codes, it is flagged last, and the block goes back to hunting for a start code.
- R8: A write completes without error only if its response has exactly 4 bytes and bytes 2 and 3, read as a big-endian value, equal the requested size. Otherwise err is set with done.
- R9: A read completes without error only if its response has exactly size bytes. Otherwise err is set with done.
- R10: While tx_ready is low, an offered outgoing byte keeps tx_valid high and tx_data unchanged.
- R11: req_ready is low from the cycle after a request is accepted until done. done is a one-cycle pulse in the cycle after the final response byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transaction request offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 for a write transaction, 0 for a read |
| req_size | input | 16 | Transaction byte count |
| req_addr | input | 32 | Target register address |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken |
| wr_data | input | 8 | Write payload byte |
| tx_valid | output | 1 | Outgoing packet byte valid |
| tx_ready | input | 1 | Link accepts the outgoing byte |
| tx_data | output | 8 | Outgoing packet byte |
| rx_valid | input | 1 | Incoming link byte valid |
| rx_ready | output | 1 | Incoming byte consumed |
| rx_data | input | 8 | Incoming link byte |
| rsp_valid | output | 1 | Recovered response byte valid |
| rsp_ready | input | 1 | Downstream accepts the response byte |
| rsp_data | output | 8 | Recovered response byte |
| rsp_last | output | 1 | Response byte is the final one of its packet |
| done | output | 1 | One-cycle transaction completion pulse |
| err | output | 1 | Response check failed, valid with done |

## Verification
The bench targets these corner cases:
- A reserved value in the last body byte, which must come out as the end marker, then the escape code, then the flipped byte. A framer that escaped before placing the end marker would split the pair.
- Reserved values inside the address field, which a design that escaped only the payload would send raw.
- The size-4 to size-5 opcode boundary, where an off-by-one comparison would pick the sequential opcode one size too early.
- On receive, a stray end marker before the start code, which a deframer that did not hunt would turn into a false last byte.
- An escaped final byte after the end marker, which a careless deframer would output as the raw escape code.
- A write echo with the wrong size and a short read, which a checker that only counted bytes, or only compared the echo, would pass.

// File: rtl/txn_frame_pkg.sv
`timescale 1ns/1ps
package txn_frame_pkg;
  localparam int SIZE_W  = 16;
  localparam int ADDR_W  = 32;
  localparam int CNT_W   = SIZE_W + 1;
  localparam int HDR_LEN = 8;

  localparam logic [7:0] CODE_SOP  = 8'h7A;
  localparam logic [7:0] CODE_EOP  = 8'h7B;
  localparam logic [7:0] CODE_CHN  = 8'h7C;
  localparam logic [7:0] CODE_ESC  = 8'h7D;
  localparam logic [7:0] ESC_FLIP  = 8'h20;

  localparam logic [7:0] OP_RD_BIT  = 8'h10;
  localparam logic [7:0] OP_SEQ_BIT = 8'h04;

  // any of the four framing codes
  function automatic logic is_reserved(input logic [7:0] b);
    return (b == CODE_SOP) || (b == CODE_EOP) || (b == CODE_CHN) || (b == CODE_ESC);
  endfunction

  // codes that make the receiver unescape the following byte
  function automatic logic is_prefix(input logic [7:0] b);
    return (b == CODE_SOP) || (b == CODE_CHN) || (b == CODE_ESC);
  endfunction

  function automatic logic [7:0] opcode(input logic wr, input logic [SIZE_W-1:0] sz,
                                        input int unsigned seq_limit);
    logic [7:0] op;
    op = wr ? 8'h00 : OP_RD_BIT;
    if (32'(sz) > seq_limit) op = op | OP_SEQ_BIT;
    return op;
  endfunction

  function automatic logic [7:0] hdr_byte(input logic [7:0] op, input logic [SIZE_W-1:0] sz,
                                          input logic [ADDR_W-1:0] addr, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = op;
      3'd1: b = 8'h00;
      3'd2: b = sz[15:8];
      3'd3: b = sz[7:0];
      3'd4: b = addr[31:24];
      3'd5: b = addr[23:16];
      3'd6: b = addr[15:8];
      default: b = addr[7:0];
    endcase
    return b;
  endfunction

  // response verdict: 1 means the response is wrong
  function automatic logic resp_bad(input logic wr, input logic [SIZE_W-1:0] sz,
                                    input logic [CNT_W-1:0] total, input logic [7:0] hi,
                                    input logic [7:0] lo, input int unsigned wr_len);
    if (wr) return (32'(total) != wr_len) || ({hi, lo} != sz);
    return total != {1'b0, sz};
  endfunction
endpackage

// File: rtl/txn_tx_packer.sv
`timescale 1ns/1ps
module txn_tx_packer
  import txn_frame_pkg::*;
#(
  parameter int unsigned SEQ_LIMIT = 4,
  parameter logic [7:0]  CHAN_ID   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [SIZE_W-1:0] start_size,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_busy
);
  typedef enum logic [2:0] {T_IDLE, T_SOP, T_CHN, T_NUM, T_BODY, T_ESC} tstate_t;

  tstate_t           state_q;
  logic [7:0]        op_q;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  idx_q, last_q;
  logic              eop_sent_q, have_q;
  logic [7:0]        hold_q;

  logic       in_hdr, cur_ok, at_last, need_eop, fire, body_step, cur_rsv;
  logic [7:0] cur_byte;

  assign in_hdr   = idx_q < CNT_W'(HDR_LEN);
  assign cur_byte = in_hdr ? hdr_byte(op_q, size_q, addr_q, idx_q[2:0]) : hold_q;
  assign cur_rsv  = is_reserved(cur_byte);
  assign cur_ok   = in_hdr | have_q;
  assign at_last  = idx_q == last_q;
  assign need_eop = at_last & ~eop_sent_q;

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    case (state_q)
      T_SOP: begin tx_valid = 1'b1; tx_data = CODE_SOP; end
      T_CHN: begin tx_valid = 1'b1; tx_data = CODE_CHN; end
      T_NUM: begin tx_valid = 1'b1; tx_data = CHAN_ID;  end
      T_BODY: begin
        if (need_eop) begin
          tx_valid = 1'b1;
          tx_data  = CODE_EOP;
        end else if (cur_ok) begin
          tx_valid = 1'b1;
          tx_data  = cur_rsv ? CODE_ESC : cur_byte;
        end
      end
      T_ESC: begin tx_valid = 1'b1; tx_data = cur_byte ^ ESC_FLIP; end
      default: ;
    endcase
  end

  assign wr_ready  = (state_q == T_BODY) & ~in_hdr & ~have_q;
  assign fire      = tx_valid & tx_ready;
  assign body_step = fire & (((state_q == T_BODY) & ~need_eop & ~cur_rsv) | (state_q == T_ESC));
  assign tx_busy   = state_q != T_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= T_IDLE;
      op_q       <= 8'h00;
      size_q     <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      last_q     <= '0;
      eop_sent_q <= 1'b0;
      have_q     <= 1'b0;
      hold_q     <= 8'h00;
    end else begin
      if (wr_valid && wr_ready) begin
        have_q <= 1'b1;
        hold_q <= wr_data;
      end
      case (state_q)
        T_IDLE: if (start) begin
          op_q       <= opcode(start_write, start_size, SEQ_LIMIT);
          size_q     <= start_size;
          addr_q     <= start_addr;
          last_q     <= start_write ? CNT_W'(start_size) + CNT_W'(HDR_LEN - 1)
                                    : CNT_W'(HDR_LEN - 1);
          idx_q      <= '0;
          eop_sent_q <= 1'b0;
          have_q     <= 1'b0;
          state_q    <= T_SOP;
        end
        T_SOP: if (fire) state_q <= T_CHN;
        T_CHN: if (fire) state_q <= T_NUM;
        T_NUM: if (fire) state_q <= T_BODY;
        T_BODY: begin
          if (fire && need_eop) eop_sent_q <= 1'b1;
          else if (fire && cur_rsv) state_q <= T_ESC;
        end
        default: ;
      endcase
      if (body_step) begin
        have_q <= 1'b0;
        if (at_last) state_q <= T_IDLE;
        else begin
          idx_q   <= idx_q + 1'b1;
          state_q <= T_BODY;
        end
      end
    end
  end

  AST_SOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start && !tx_busy |=> tx_valid && tx_data == CODE_SOP); // R2
  AST_EOP_BEFORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (state_q == T_BODY) && tx_data == CODE_EOP |=> at_last && (state_q == T_BODY)); // R3
  AST_ESC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tx_data == CODE_ESC |=> tx_valid && !is_reserved(tx_data)); // R4
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10
endmodule

// File: rtl/txn_rx_unpacker.sv
`timescale 1ns/1ps
module txn_rx_unpacker
  import txn_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data,
  output logic       rsp_last
);
  typedef enum logic [2:0] {R_HUNT, R_BODY, R_ESC, R_TAIL, R_TESC} rstate_t;

  rstate_t state_q;
  logic    emit, take, hunting, pfx;

  assign pfx     = is_prefix(rx_data);
  assign hunting = state_q == R_HUNT;

  always_comb begin
    emit     = 1'b0;
    rsp_last = 1'b0;
    rsp_data = rx_data;
    case (state_q)
      R_BODY: emit = !pfx && rx_data != CODE_EOP;
      R_ESC:  begin emit = 1'b1; rsp_data = rx_data ^ ESC_FLIP; end
      R_TAIL: begin emit = !pfx; rsp_last = 1'b1; end
      R_TESC: begin emit = 1'b1; rsp_last = 1'b1; rsp_data = rx_data ^ ESC_FLIP; end
      default: ;
    endcase
  end

  assign rsp_valid = rx_valid & emit;
  assign rx_ready  = emit ? rsp_ready : 1'b1;
  assign take      = rx_valid & rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= R_HUNT;
    else if (take) begin
      case (state_q)
        R_HUNT: if (rx_data == CODE_SOP) state_q <= R_BODY;
        R_BODY: begin
          if (pfx) state_q <= R_ESC;
          else if (rx_data == CODE_EOP) state_q <= R_TAIL;
        end
        R_ESC:  state_q <= R_BODY;
        R_TAIL: state_q <= pfx ? R_TESC : R_HUNT;
        default: state_q <= R_HUNT;
      endcase
    end
  end

  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> !rsp_valid); // R6
  AST_LAST_REHUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && rsp_last |=> hunting); // R7
endmodule

// File: rtl/txn_resp_check.sv
`timescale 1ns/1ps
module txn_resp_check
  import txn_frame_pkg::*;
#(
  parameter int unsigned WR_RSP_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [SIZE_W-1:0] start_size,
  input  logic              beat,
  input  logic [7:0]        beat_data,
  input  logic              beat_last,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic              write_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  cnt_q, total;
  logic [7:0]        hi_q, lo_q, hi_n, lo_n;
  logic              take;

  assign take  = busy & beat;
  assign total = cnt_q + 1'b1;
  assign hi_n  = (cnt_q == CNT_W'(2)) ? beat_data : hi_q;
  assign lo_n  = (cnt_q == CNT_W'(3)) ? beat_data : lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      write_q <= 1'b0;
      size_q  <= '0;
      cnt_q   <= '0;
      hi_q    <= 8'h00;
      lo_q    <= 8'h00;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        err     <= 1'b0;
        write_q <= start_write;
        size_q  <= start_size;
        cnt_q   <= '0;
      end else if (take) begin
        hi_q <= hi_n;
        lo_q <= lo_n;
        if (beat_last) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          err   <= resp_bad(write_q, size_q, total, hi_n, lo_n, WR_RSP_LEN);
          cnt_q <= '0;
        end else if (cnt_q != '1) begin
          cnt_q <= total;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy); // R11
endmodule

// File: rtl/txn_framer.sv
`timescale 1ns/1ps
module txn_framer
  import txn_frame_pkg::*;
#(
  parameter int unsigned SEQ_LIMIT  = 4,
  parameter int unsigned WR_RSP_LEN = 4,
  parameter logic [7:0]  CHAN_ID    = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [15:0] req_size,
  input  logic [31:0] req_addr,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [7:0]  wr_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [7:0]  rsp_data,
  output logic        rsp_last,
  output logic        done,
  output logic        err
);
  logic start, tx_busy, chk_busy;

  assign req_ready = ~(tx_busy | chk_busy);
  assign start     = req_valid & req_ready;

  txn_tx_packer #(.SEQ_LIMIT(SEQ_LIMIT), .CHAN_ID(CHAN_ID)) i_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write),
    .start_size(req_size), .start_addr(req_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_busy(tx_busy));

  txn_rx_unpacker i_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last));

  txn_resp_check #(.WR_RSP_LEN(WR_RSP_LEN)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write), .start_size(req_size),
    .beat(rsp_valid & rsp_ready), .beat_data(rsp_data), .beat_last(rsp_last),
    .busy(chk_busy), .done(done), .err(err));

  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !req_ready); // R11
endmodule

// File: tb/test_txn_framer.sv
`timescale 1ns/1ps
module test_txn_framer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_size = 0;
  logic [31:0] req_addr = 0;
  logic wr_valid = 0, tx_ready = 0, rx_valid = 0, rsp_ready = 1;
  logic [7:0] wr_data = 0, rx_data = 0;
  logic req_ready, wr_ready, tx_valid, rx_ready, rsp_valid, rsp_last, done, err;
  logic [7:0] tx_data, rsp_data;

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0, last_cnt = 0;
  bit err_seen = 0, finished = 0;
  logic [7:0] tx_seen[$], rsp_seen[$];

  always #2.5 clk = ~clk;

  txn_framer i_txn_framer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
    .done(done), .err(err));

  // link backpressure pattern
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= (cyc % 3) != 2;
  end

  // monitor: 1 ns before each rising edge
  always @(negedge clk) begin
    #1.5;
    if (tx_valid && tx_ready) tx_seen.push_back(tx_data);
    if (rsp_valid && rsp_ready) begin
      rsp_seen.push_back(rsp_data);
      if (rsp_last) last_cnt++;
    end
    if (done) begin done_cnt++; err_seen = err; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_q(input string req, input string what, input logic [7:0] act[$], input logic [7:0] exp[$]);
    int bad = -1;
    for (int i = 0; i < exp.size(); i++)
      if (bad < 0 && (i >= act.size() || act[i] !== exp[i])) bad = i;
    if (bad < 0 && act.size() != exp.size()) bad = exp.size();
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s %s: index %0d actual 0x%0h expected 0x%0h (len %0d vs %0d)", req, what, bad,
               (bad < act.size()) ? act[bad] : 8'hxx, (bad < exp.size()) ? exp[bad] : 8'hxx,
               act.size(), exp.size());
    end
  endtask

  // expected outgoing packet, built from the framing rules
  function automatic void build_tx(input bit w, input int sz, input logic [31:0] a,
                                   input logic [7:0] pl[$], ref logic [7:0] q[$]);
    logic [7:0] body[$];
    logic [7:0] op;
    op = w ? 8'h00 : 8'h10;
    if (sz > 4) op = op + 8'h04;
    body = '{op, 8'h00, 8'(sz >> 8), 8'(sz), a[31:24], a[23:16], a[15:8], a[7:0]};
    if (w) foreach (pl[i]) body.push_back(pl[i]);
    q = '{8'h7A, 8'h7C, 8'h00};
    foreach (body[i]) begin
      if (i == body.size() - 1) q.push_back(8'h7B);
      if (body[i] >= 8'h7A && body[i] <= 8'h7D) begin
        q.push_back(8'h7D);
        q.push_back(body[i] ^ 8'h20);
      end else q.push_back(body[i]);
    end
  endfunction

  task automatic drive_req(input bit w, input int sz, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1; req_write = w; req_size = 16'(sz); req_addr = a;
    forever begin #1.5; if (req_ready) break; @(negedge clk); end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drive_wr(input logic [7:0] pl[$]);
    foreach (pl[i]) begin
      @(negedge clk);
      wr_valid = 1; wr_data = pl[i];
      forever begin #1.5; if (wr_ready) break; @(negedge clk); end
    end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic drive_rx(input logic [7:0] b[$]);
    foreach (b[i]) begin
      @(negedge clk);
      rx_valid = 1; rx_data = b[i];
      forever begin #1.5; if (rx_ready) break; @(negedge clk); end
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic wait_tx(input int n);
    for (int k = 0; k < 3000 && tx_seen.size() < n; k++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000 && done_cnt == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_txn(input string req, input bit w, input int sz, input logic [31:0] a,
                         input logic [7:0] pl[$], input logic [7:0] rxb[$],
                         input logic [7:0] exp_rsp[$], input bit exp_err, input string err_req);
    logic [7:0] exp_tx[$];
    build_tx(w, sz, a, pl, exp_tx);
    tx_seen.delete(); rsp_seen.delete(); done_cnt = 0; last_cnt = 0;
    fork
      drive_req(w, sz, a);
      drive_wr(pl);
    join
    wait_tx(exp_tx.size());
    drive_rx(rxb);
    wait_done();
    chk_q(req, "tx packet", tx_seen, exp_tx);
    chk_q("R7", "response bytes", rsp_seen, exp_rsp);
    chk(last_cnt == 1, "R7", "last flag count", last_cnt, 1);
    chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
    chk(err_seen == exp_err, err_req, "err", err_seen, exp_err);
  endtask

  task automatic t_reset();
    #1.5;
    chk(req_ready == 1, "R11", "reset req_ready", req_ready, 1);
    chk(tx_valid == 0, "R2", "reset tx_valid", tx_valid, 0);
    chk(rsp_valid == 0, "R6", "reset rsp_valid", rsp_valid, 0);
    chk(done == 0, "R11", "reset done", done, 0);
  endtask

  task automatic t_read_single();
    run_txn("R1", 0, 4, 32'h0030_043C, '{},
            '{8'h4A, 8'h11, 8'h7A, 8'h87, 8'h65, 8'h43, 8'h7B, 8'h21},
            '{8'h87, 8'h65, 8'h43, 8'h21}, 0, "R9");
    chk(tx_seen.size() > 3 && tx_seen[3] == 8'h10, "R1", "read opcode size 4", tx_seen[3], 8'h10);
    chk(tx_seen.size() == 12, "R5", "read packet is header only", tx_seen.size(), 12);
  endtask

  task automatic t_write_seq();
    run_txn("R4", 1, 6, 32'h127C_0055, '{8'h11, 8'h7A, 8'h22, 8'h7D, 8'h33, 8'h7B},
            '{8'h7A, 8'h00, 8'h00, 8'h00, 8'h7B, 8'h06},
            '{8'h00, 8'h00, 8'h00, 8'h06}, 0, "R8");
    chk(tx_seen.size() > 3 && tx_seen[3] == 8'h04, "R1", "seq write opcode", tx_seen[3], 8'h04);
    chk(tx_seen.size() >= 3 && tx_seen[tx_seen.size()-3] == 8'h7B, "R3", "end marker before escaped last",
        tx_seen[tx_seen.size()-3], 8'h7B);
  endtask

  task automatic t_write_bad_echo();
    run_txn("R5", 1, 4, 32'h0000_0100, '{8'h7B, 8'h01, 8'h02, 8'h7C},
            '{8'h7A, 8'h00, 8'h00, 8'h00, 8'h7B, 8'h03},
            '{8'h00, 8'h00, 8'h00, 8'h03}, 1, "R8");
    chk(tx_seen.size() > 3 && tx_seen[3] == 8'h00, "R1", "single write opcode size 4", tx_seen[3], 8'h00);
  endtask

  task automatic t_read_escapes();
    run_txn("R4", 0, 4, 32'h0000_7D7A, '{},
            '{8'h4A, 8'h7B, 8'h7A, 8'h7D, 8'h5A, 8'h11, 8'h7C, 8'h5D, 8'h7B, 8'h7D, 8'h5B},
            '{8'h7A, 8'h11, 8'h7D, 8'h7B}, 0, "R6");
  endtask

  task automatic t_read_short();
    run_txn("R1", 0, 8, 32'hDEAD_BEEF, '{},
            '{8'h7A, 8'h01, 8'h02, 8'h7B, 8'h03},
            '{8'h01, 8'h02, 8'h03}, 1, "R9");
    chk(tx_seen.size() > 3 && tx_seen[3] == 8'h14, "R1", "seq read opcode", tx_seen[3], 8'h14);
  endtask

  task automatic t_busy();
    logic [7:0] exp_tx[$];
    int blocked = 0;
    build_tx(0, 1, 32'hA5A5_A5A5, '{}, exp_tx);
    tx_seen.delete(); rsp_seen.delete(); done_cnt = 0; last_cnt = 0;
    drive_req(0, 1, 32'hA5A5_A5A5);
    req_valid = 1; req_write = 1; req_size = 16'd9; req_addr = 32'h1111_1111;
    for (int k = 0; k < 6; k++) begin @(negedge clk); #1.5; if (!req_ready) blocked++; end
    wait_tx(exp_tx.size());
    req_valid = 0;
    drive_rx('{8'h7A, 8'h7B, 8'h5E});
    wait_done();
    chk(blocked == 6, "R11", "req_ready low while busy", blocked, 6);
    chk_q("R11", "only first request framed", tx_seen, exp_tx);
    chk_q("R7", "single byte response", rsp_seen, '{8'h5E});
    chk(done_cnt == 1 && err_seen == 0, "R9", "size 1 read ok", err_seen, 0);
    #1.5;
    chk(done == 0, "R11", "done is a pulse", done, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_read_single();
    t_write_seq();
    t_write_bad_echo();
    t_read_escapes();
    t_read_short();
    t_busy();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule